// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block decides when a pending, vectored interrupt request may take control of a small 4-bit processor core, and then steps the core through handler entry. It follows each instruction the core runs from a start pulse and a length code. It accepts a request only in the last cycle of an instruction, or in any cycle while the core is halted. It never accepts a request at the end of a page-select instruction, so that instruction and the jump or call after it are never split.

Once a request is accepted, the sequencer runs two interrupt cycles of `INT_CYCLES` clocks each and then a single jump cycle. During the first interrupt cycle it emits the return address (page, then the high step nibble, then the low step nibble) as three strobed nibbles for the core's stack. In the first clock of that cycle it also pulses a clear for the core's interrupt-enable flag. In the jump cycle it drives a forced program-address load. The load targets bank 0, page 1, with the step equal to the request's vector number (1 to 15). A request that wakes the core from halt gets one extra wake clock before the first interrupt cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `entry_busy`, `ien_clr`, `push_stb` and `pc_load` are all low.
- R2: A request is accepted only in the last cycle of the running instruction. The length code sets that instruction's length: 0 gives 5 cycles, 1 gives 7 cycles, and 2 or 3 give 12 cycles. The first interrupt cycle starts in the cycle after that last cycle.
- R3: In three consecutive cycles, starting in the cycle after acceptance, `push_stb` is high and `push_nib` carries `pc_page`, then `pc_step[7:4]`, then `pc_step[3:0]`. These values are captured in the acceptance cycle.
- R4: `ien_clr` is a one-cycle pulse in the same cycle as the first push.
- R5: `pc_load` is high for one cycle, 13 cycles after the acceptance cycle. In that cycle `pc_load_addr` = {bank bit 0, page 4'h1, step = vector zero-extended to 8 bits}, i.e. 13'h100 | vector.
- R6: While `ien_flag` is 0, a request is not accepted. A request held pending is accepted at the first instruction end after `ien_flag` becomes 1.
- R7: A vector value of 0 counts as no request.
- R8: When the instruction that ends carries `instr_pset`=1, no request is accepted at its end. Acceptance moves to the end of the next instruction.
- R9: While `halted` is 1, a request is accepted in any cycle. One wake cycle is then inserted, so the first push comes 2 cycles and `pc_load` 14 cycles after the acceptance cycle.
- R10: `entry_busy` is high from the cycle after acceptance through the `pc_load` cycle. Instruction start pulses are ignored during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Level interrupt request |
| irq_vec | input | 4 | Vector number of the request (0 = none) |
| ien_flag | input | 1 | Core interrupt-enable flag |
| instr_start | input | 1 | Pulse in the first cycle of an instruction |
| instr_len | input | 2 | Length code of the starting instruction |
| instr_pset | input | 1 | Starting instruction is a page select |
| halted | input | 1 | Core is halted or sleeping |
| pc_page | input | 4 | Page of the return address |
| pc_step | input | 8 | Step of the return address |
| entry_busy | output | 1 | Entry sequence in progress |
| ien_clr | output | 1 | Clear pulse for the enable flag |
| push_stb | output | 1 | Stack push strobe |
| push_nib | output | 4 | Nibble to push |
| pc_load | output | 1 | Forced program-address load |
| pc_load_addr | output | 13 | Bank, page, step of the vector |

## Verification
For every stimulus, the bench computes the acceptance cycle from the start cycle and the instruction length: start cycle + length - 1, or the cycle in which halt and the request coincide. It then places each result at a fixed offset from that cycle. The enable clear and the first push come 1 cycle later, and the other pushes 2 and 3 cycles later. The vector load comes 13 cycles later, with one more cycle added after halt. Each expected item carries its cycle number into a queue. Outputs are sampled on the falling edge and compared against the head of the queue, so an early, late, missing or extra strobe is caught in the exact cycle it occurs.

// File: rtl/ies_pkg.sv
package ies_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAKE,
      ST_INT1,
      ST_INT2,
      ST_JUMP
   } ies_state_e;

endpackage

// File: rtl/ies_boundary.sv
module ies_boundary #(
   parameter int LEN_SHORT = 5,
   parameter int LEN_MID   = 7,
   parameter int LEN_LONG  = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       instr_start,
   input  logic [1:0] instr_len,
   input  logic       instr_pset,
   input  logic       hold,
   output logic       boundary,
   output logic       defer
);

   localparam int REM_W = $clog2(LEN_LONG + 1);

   logic             run_q;
   logic [REM_W-1:0] rem_q;
   logic             pset_q;
   logic [REM_W-1:0] load_val;
   logic             start_ok;

   assign start_ok = instr_start && !hold;

   always_comb begin
      case (instr_len)
         2'd0:    load_val = REM_W'(LEN_SHORT - 1);
         2'd1:    load_val = REM_W'(LEN_MID - 1);
         default: load_val = REM_W'(LEN_LONG - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         rem_q  <= '0;
         pset_q <= 1'b0;
      end else if (start_ok) begin
         run_q  <= 1'b1;
         rem_q  <= load_val;
         pset_q <= instr_pset;
      end else if (boundary) begin
         run_q  <= 1'b0;
      end else if (run_q) begin
         rem_q  <= rem_q - 1'b1;
      end
   end

   assign boundary = run_q && (rem_q == REM_W'(1));
   assign defer    = pset_q;

   // R2
   rem_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (rem_q != '0));

   // R2
   bnd_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !start_ok) |=> !run_q);

endmodule

// File: rtl/ies_fsm.sv
module ies_fsm
   import ies_pkg::*;
#(
   parameter int INT_CYCLES  = 6,
   parameter int WAKE_CYCLES = 1,
   parameter int N_PUSH      = 3,
   parameter int VEC_W       = 4,
   parameter int PIDX_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [VEC_W-1:0]  vec,
   input  logic              ien,
   input  logic              accept_ok,
   input  logic              halted,
   output logic              busy,
   output logic              take,
   output logic              push_stb,
   output logic [PIDX_W-1:0] push_idx,
   output logic              ien_clr,
   output logic              pc_load,
   output logic [VEC_W-1:0]  vec_q
);

   localparam int CNT_MAX   = (INT_CYCLES > WAKE_CYCLES) ? INT_CYCLES : WAKE_CYCLES;
   localparam int CNT_W     = $clog2(CNT_MAX + 1);
   localparam int WAKE_LAST = (WAKE_CYCLES > 0) ? WAKE_CYCLES - 1 : 0;

   ies_state_e       state_q;
   ies_state_e       first_st;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (WAKE_CYCLES == 0) begin : g_nowake
         assign first_st = ST_INT1;
      end else begin : g_wake
         assign first_st = halted ? ST_WAKE : ST_INT1;
      end
   endgenerate

   assign take = (state_q == ST_IDLE) && req && (vec != '0) && ien
                 && (accept_ok || halted);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         vec_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (take) begin
                  vec_q   <= vec;
                  cnt_q   <= '0;
                  state_q <= first_st;
               end
            end
            ST_WAKE: begin
               if (cnt_q == CNT_W'(WAKE_LAST)) begin
                  cnt_q   <= '0;
                  state_q <= ST_INT1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_INT1: begin
               if (cnt_q == CNT_W'(INT_CYCLES - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_INT2;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_INT2: begin
               if (cnt_q == CNT_W'(INT_CYCLES - 1)) begin
                  cnt_q   <= '0;
                  state_q <= ST_JUMP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign push_stb = (state_q == ST_INT1) && (cnt_q < CNT_W'(N_PUSH));
   assign push_idx = PIDX_W'(cnt_q);
   assign ien_clr  = (state_q == ST_INT1) && (cnt_q == '0);
   assign pc_load  = (state_q == ST_JUMP);

   // R4
   clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr |=> !ien_clr);

   // R6
   ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_IDLE) && !ien) |=> (state_q == ST_IDLE));

   // R10
   load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |=> (!busy && !pc_load));

   // R3
   push_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ien_clr |=> push_stb);

endmodule

// File: rtl/ies_ret_push.sv
module ies_ret_push #(
   parameter int PAGE_W = 4,
   parameter int STEP_W = 8,
   parameter int NIB_W  = 4,
   parameter int N_PUSH = 3,
   parameter int PIDX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [PAGE_W-1:0] pc_page,
   input  logic [STEP_W-1:0] pc_step,
   input  logic [PIDX_W-1:0] idx,
   output logic [NIB_W-1:0]  nib
);

   localparam int RET_W = PAGE_W + STEP_W;

   logic [RET_W-1:0] ret_q;
   logic [NIB_W-1:0] nib_arr [N_PUSH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_q <= '0;
      end else if (capture) begin
         ret_q <= {pc_page, pc_step};
      end
   end

   for (genvar g = 0; g < N_PUSH; g++) begin : g_nib
      assign nib_arr[g] = ret_q[RET_W-1-g*NIB_W -: NIB_W];
   end

   assign nib = nib_arr[idx];

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
   parameter int PAGE_W       = 4,
   parameter int STEP_W       = 8,
   parameter int BANK_W       = 1,
   parameter int NIB_W        = 4,
   parameter int VEC_W        = 4,
   parameter int LEN_SHORT    = 5,
   parameter int LEN_MID      = 7,
   parameter int LEN_LONG     = 12,
   parameter int INT_CYCLES   = 6,
   parameter int WAKE_CYCLES  = 1,
   parameter int HANDLER_PAGE = 1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              irq_req,
   input  logic [VEC_W-1:0]                  irq_vec,
   input  logic                              ien_flag,
   input  logic                              instr_start,
   input  logic [1:0]                        instr_len,
   input  logic                              instr_pset,
   input  logic                              halted,
   input  logic [PAGE_W-1:0]                 pc_page,
   input  logic [STEP_W-1:0]                 pc_step,
   output logic                              entry_busy,
   output logic                              ien_clr,
   output logic                              push_stb,
   output logic [NIB_W-1:0]                  push_nib,
   output logic                              pc_load,
   output logic [BANK_W+PAGE_W+STEP_W-1:0]   pc_load_addr
);

   localparam int RET_W  = PAGE_W + STEP_W;
   localparam int N_PUSH = RET_W / NIB_W;
   localparam int PIDX_W = (N_PUSH > 1) ? $clog2(N_PUSH) : 1;

   generate
      if (RET_W % NIB_W != 0) begin : g_bad_nib
         $error("return address width must be a whole number of nibbles");
      end
      if (INT_CYCLES < N_PUSH) begin : g_bad_int
         $error("interrupt cycle too short for the pushes");
      end
      if (VEC_W > STEP_W) begin : g_bad_vec
         $error("vector wider than step field");
      end
      if (LEN_SHORT < 2 || LEN_MID < 2 || LEN_LONG < 2) begin : g_bad_len
         $error("instruction length must be at least 2");
      end
   endgenerate

   logic              bnd;
   logic              defer;
   logic              accept_ok;
   logic              take;
   logic [PIDX_W-1:0] push_idx;
   logic [VEC_W-1:0]  vec_q;

   ies_boundary #(
      .LEN_SHORT (LEN_SHORT),
      .LEN_MID   (LEN_MID),
      .LEN_LONG  (LEN_LONG)
   ) u_bnd (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_start (instr_start),
      .instr_len   (instr_len),
      .instr_pset  (instr_pset),
      .hold        (entry_busy),
      .boundary    (bnd),
      .defer       (defer)
   );

   assign accept_ok = bnd && !defer;

   ies_fsm #(
      .INT_CYCLES  (INT_CYCLES),
      .WAKE_CYCLES (WAKE_CYCLES),
      .N_PUSH      (N_PUSH),
      .VEC_W       (VEC_W),
      .PIDX_W      (PIDX_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (irq_req),
      .vec       (irq_vec),
      .ien       (ien_flag),
      .accept_ok (accept_ok),
      .halted    (halted),
      .busy      (entry_busy),
      .take      (take),
      .push_stb  (push_stb),
      .push_idx  (push_idx),
      .ien_clr   (ien_clr),
      .pc_load   (pc_load),
      .vec_q     (vec_q)
   );

   ies_ret_push #(
      .PAGE_W (PAGE_W),
      .STEP_W (STEP_W),
      .NIB_W  (NIB_W),
      .N_PUSH (N_PUSH),
      .PIDX_W (PIDX_W)
   ) u_push (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (take),
      .pc_page (pc_page),
      .pc_step (pc_step),
      .idx     (push_idx),
      .nib     (push_nib)
   );

   assign pc_load_addr = {BANK_W'(0), PAGE_W'(HANDLER_PAGE), STEP_W'(vec_q)};

   // R3
   push_vs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push_stb, pc_load}));

   // R8
   pset_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && defer && !halted && !entry_busy) |=> !entry_busy);

   // R7
   load_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_load |-> (pc_load_addr[STEP_W-1:0] != '0));

   // R6
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(entry_busy) |-> $past(irq_req && ien_flag));

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

   typedef struct {
      int    cyc;
      int    kind;
      int    data;
      string rq;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 1'b0;
   logic [3:0]  irq_vec = '0;
   logic        ien_flag = 1'b0;
   logic        instr_start = 1'b0;
   logic [1:0]  instr_len = '0;
   logic        instr_pset = 1'b0;
   logic        halted = 1'b0;
   logic [3:0]  pc_page = '0;
   logic [7:0]  pc_step = '0;
   logic        entry_busy;
   logic        ien_clr;
   logic        push_stb;
   logic [3:0]  push_nib;
   logic        pc_load;
   logic [12:0] pc_load_addr;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sbq[$];

   irq_entry_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_req      (irq_req),
      .irq_vec      (irq_vec),
      .ien_flag     (ien_flag),
      .instr_start  (instr_start),
      .instr_len    (instr_len),
      .instr_pset   (instr_pset),
      .halted       (halted),
      .pc_page      (pc_page),
      .pc_step      (pc_step),
      .entry_busy   (entry_busy),
      .ien_clr      (ien_clr),
      .push_stb     (push_stb),
      .push_nib     (push_nib),
      .pc_load      (pc_load),
      .pc_load_addr (pc_load_addr)
   );

   always #4 clk = ~clk;

   always @(posedge clk) cyc++;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
      end
   endtask

   task automatic match(input int kind, input int data);
      exp_t e;
      if (sbq.size() == 0) begin
         checks++;
         errors++;
         $display("FAIL R6/R7/R8 unexpected strobe kind %0d: actual %0d expected none (cycle %0d)",
                  kind, data, cyc);
      end else begin
         e = sbq.pop_front();
         checks++;
         if (e.kind != kind || e.data != data || e.cyc != cyc) begin
            errors++;
            $display("FAIL %s: actual kind %0d data %0h cycle %0d expected kind %0d data %0h cycle %0d",
                     e.rq, kind, data, cyc, e.kind, e.data, e.cyc);
         end
      end
   endtask

   // monitor: pops the scoreboard as strobes appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (ien_clr)  match(0, 0);
         if (push_stb) match(1, int'(push_nib));
         if (pc_load)  match(2, int'(pc_load_addr));
      end
   end

   function automatic int len_cycles(input int code);
      case (code)
         0:       return 5;
         1:       return 7;
         default: return 12;
      endcase
   endfunction

   task automatic add_exp(input int c, input int k, input int d, input string rq);
      exp_t e;
      e.cyc = c; e.kind = k; e.data = d; e.rq = rq;
      sbq.push_back(e);
   endtask

   // b = acceptance cycle, w = wake cycles
   task automatic expect_entry(input int b, input int w, input int vec,
                               input int page, input int step, input string rq);
      add_exp(b + 1 + w, 0, 0, "R4");
      add_exp(b + 1 + w, 1, page, "R3");
      add_exp(b + 2 + w, 1, (step >> 4) & 15, "R3");
      add_exp(b + 3 + w, 1, step & 15, "R3");
      add_exp(b + 13 + w, 2, 256 | vec, rq);
   endtask

   task automatic run_instr(input int code, input bit ps);
      int n;
      n = len_cycles(code);
      instr_start = 1'b1;
      instr_len   = 2'(code);
      instr_pset  = ps;
      @(negedge clk);
      instr_start = 1'b0;
      instr_pset  = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic wait_to(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic serve(input int code, input int vec, input int page,
                        input int step, input string rq);
      int b;
      pc_page = 4'(page);
      pc_step = 8'(step);
      irq_vec = 4'(vec);
      irq_req = 1'b1;
      b = cyc + len_cycles(code) - 1;
      expect_entry(b, 0, vec, page, step, rq);
      run_instr(code, 1'b0);
      chk(entry_busy == 1'b1, "R10", int'(entry_busy), 1);
      wait_to(b + 13);
      irq_req = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog expired: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(entry_busy == 1'b0, "R1", int'(entry_busy), 0);
      chk(pc_load == 1'b0, "R1", int'(pc_load), 0);
      chk(push_stb == 1'b0, "R1", int'(push_stb), 0);
      chk(ien_clr == 1'b0, "R1", int'(ien_clr), 0);

      ien_flag = 1'b1;
      // R2 / R5: the three length codes plus the alias code
      serve(0, 3, 'hA, 'h5C, "R5");
      serve(1, 9, 'h3, 'hF0, "R2");
      serve(2, 15, 'h0, 'h01, "R2");
      serve(3, 7, 'h6, 'hA5, "R2");

      // R6: disabled requests are ignored, served once enabled
      ien_flag = 1'b0;
      irq_vec  = 4'd5;
      irq_req  = 1'b1;
      run_instr(0, 1'b0);
      chk(entry_busy == 1'b0, "R6", int'(entry_busy), 0);
      run_instr(1, 1'b0);
      chk(entry_busy == 1'b0, "R6", int'(entry_busy), 0);
      ien_flag = 1'b1;
      pc_page = 4'h2;
      pc_step = 8'h34;
      b = cyc + 5 - 1;
      expect_entry(b, 0, 5, 'h2, 'h34, "R6");
      run_instr(0, 1'b0);
      wait_to(b + 13);
      irq_req = 1'b0;
      repeat (2) @(negedge clk);

      // R7: vector zero is no request
      irq_vec = 4'd0;
      irq_req = 1'b1;
      run_instr(0, 1'b0);
      chk(entry_busy == 1'b0, "R7", int'(entry_busy), 0);
      irq_req = 1'b0;
      @(negedge clk);

      // R8: page select defers acceptance to the following transfer
      irq_vec = 4'd2;
      pc_page = 4'h9;
      pc_step = 8'h7E;
      irq_req = 1'b1;
      run_instr(0, 1'b1);
      chk(entry_busy == 1'b0, "R8", int'(entry_busy), 0);
      b = cyc + 7 - 1;
      expect_entry(b, 0, 2, 'h9, 'h7E, "R8");
      run_instr(1, 1'b0);
      wait_to(b + 13);
      irq_req = 1'b0;
      repeat (2) @(negedge clk);

      // R9: wake from halt
      irq_vec = 4'd6;
      pc_page = 4'hC;
      pc_step = 8'h12;
      halted  = 1'b1;
      irq_req = 1'b1;
      b = cyc;
      expect_entry(b, 1, 6, 'hC, 'h12, "R9");
      @(negedge clk);
      chk(entry_busy == 1'b1, "R10", int'(entry_busy), 1);
      wait_to(b + 14);
      irq_req = 1'b0;
      halted  = 1'b0;

      repeat (5) @(negedge clk);
      chk(sbq.size() == 0, "R5", sbq.size(), 0);
      chk(entry_busy == 1'b0, "R10", int'(entry_busy), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule